// File: doc/BRIEF.md
# PFC Protection and Mode Supervisor

This block watches three digitized voltages of a boost power-factor-correction stage: the auxiliary supply, the divided output bus feedback and the shunt current sense. All three arrive as signed millivolt codes that share one sample strobe. From each accepted sample it chooses the controller's operating mode (off, standby, start-up or normal). It also raises the protection requests that the analog loops and the PWM stage act on: an immediate duty cut, a gate kill, a soft current limit, a peak current limit and the two flags of the fast-response window.

The sample input is a stream with a valid strobe and no ready. The supervisor accepts every sample whose strobe is high and never applies back-pressure, so the converter front end may present a sample on any cycle. Mode and flags are registered once per accepted sample and appear one clock after the strobe edge. Between samples they hold.

Top module: `pfc_supervisor`

## Requirements
- R1: With the supply not yet qualified, a sample whose supply code is strictly above 11800 mV qualifies it. A sample at exactly 11800 mV does not.
- R2: Once qualified, the supply stays qualified until a sample is strictly below 11000 mV. Samples from 11000 to 11800 mV leave the state unchanged. An unqualified supply puts the mode in OFF.
- R3: With the supply qualified, a feedback code below 600 mV puts the mode in STANDBY.
- R4: Leaving OFF or STANDBY with the supply qualified and feedback at or above 600 mV enters STARTUP. The compensation-reset output is high exactly when the mode is OFF or STANDBY.
- R5: In STARTUP, a feedback code of 2850 mV or more moves to NORMAL. In NORMAL, a feedback code below 2490 mV returns to STARTUP.
- R6: The duty-cut flag is high when feedback is above 3150 mV. The gate-kill flag is high when feedback is above 3250 mV.
- R7: The window-high flag is high when feedback is above 3180 mV. The window-low flag is high when feedback is below 2850 mV.
- R8: The soft over-current flag is high when the current code is below -750 mV. The peak-limit flag is high when it is at or below -1040 mV.
- R9: Mode and flags change only in the clock after a cycle with the strobe high. Input values present without the strobe have no effect.
- R10: Mode encoding is OFF=0, STANDBY=1, STARTUP=2, NORMAL=3. Reset gives OFF with every flag low and the supply unqualified.
- R11: Gate enable is high only in STARTUP or NORMAL while gate-kill is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe; every strobed sample is accepted |
| vcc_mv | input | 16 | Supply voltage, signed mV |
| fb_mv | input | 16 | Output feedback voltage, signed mV |
| cs_mv | input | 16 | Current-sense voltage, signed mV |
| mode | output | 2 | Operating mode |
| gate_en | output | 1 | Gate drive permitted |
| comp_rst | output | 1 | Hold compensation nodes in reset |
| duty_cut | output | 1 | Immediate duty reduction request |
| gate_kill | output | 1 | Force gate off |
| win_hi | output | 1 | Fast-response window high |
| win_lo | output | 1 | Fast-response window low |
| soft_oc | output | 1 | Soft over-current control active |
| peak_lim | output | 1 | Peak current limit |

## Verification
The hardest case to reach is the return from NORMAL to STARTUP. It needs a qualified supply, a pass through STARTUP and a feedback rise past 2850 mV before the fall below 2490 mV can occur. The bench reaches it by sweeping feedback up and back down while the supply is held qualified. The supply sweep runs in both directions, so each code inside the hysteresis band is seen once from the qualified state and once from the unqualified state.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;
  typedef enum logic [1:0] {
    M_OFF     = 2'd0,
    M_STANDBY = 2'd1,
    M_STARTUP = 2'd2,
    M_NORMAL  = 2'd3
  } pfc_mode_e;

  typedef struct packed {
    logic duty_cut;
    logic gate_kill;
    logic win_hi;
    logic win_lo;
    logic soft_oc;
    logic peak_lim;
  } pfc_flags_t;
endpackage

// File: rtl/pfc_supply_hyst.sv
module pfc_supply_hyst #(
  parameter int W      = 16,
  parameter int ON_MV  = 11800,
  parameter int OFF_MV = 11000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic signed [W-1:0] vcc_mv,
  output logic                ok_nxt,
  output logic                ok_q
);
  localparam logic signed [W-1:0] ON_T  = W'(ON_MV);
  localparam logic signed [W-1:0] OFF_T = W'(OFF_MV);

  always_comb begin
    ok_nxt = ok_q;
    if (smp_valid) begin
      if (ok_q && (vcc_mv < OFF_T))       ok_nxt = 1'b0;
      else if (!ok_q && (vcc_mv > ON_T))  ok_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_nxt;
  end

  // R1: qualification only follows a strobed sample above the on level
  a_r1_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(smp_valid && (vcc_mv > ON_T)));
  // R2: disqualification only follows a strobed sample below the off level
  a_r2_turn_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ok_q) |-> $past(smp_valid && (vcc_mv < OFF_T)));
endmodule

// File: rtl/pfc_level_flags.sv
module pfc_level_flags
  import pfc_sup_pkg::*;
#(
  parameter int W        = 16,
  parameter int CUT_MV   = 3150,
  parameter int KILL_MV  = 3250,
  parameter int WHI_MV   = 3180,
  parameter int WLO_MV   = 2850,
  parameter int SOC_MV   = -750,
  parameter int PEAK_MV  = -1040
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic signed [W-1:0] fb_mv,
  input  logic signed [W-1:0] cs_mv,
  output pfc_flags_t          flags
);
  localparam logic signed [W-1:0] CUT_T  = W'(CUT_MV);
  localparam logic signed [W-1:0] KILL_T = W'(KILL_MV);
  localparam logic signed [W-1:0] WHI_T  = W'(WHI_MV);
  localparam logic signed [W-1:0] WLO_T  = W'(WLO_MV);
  localparam logic signed [W-1:0] SOC_T  = W'(SOC_MV);
  localparam logic signed [W-1:0] PEAK_T = W'(PEAK_MV);

  pfc_flags_t f_nxt;

  always_comb begin
    f_nxt.duty_cut  = fb_mv > CUT_T;
    f_nxt.gate_kill = fb_mv > KILL_T;
    f_nxt.win_hi    = fb_mv > WHI_T;
    f_nxt.win_lo    = fb_mv < WLO_T;
    f_nxt.soft_oc   = cs_mv < SOC_T;
    f_nxt.peak_lim  = cs_mv <= PEAK_T;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flags <= '0;
    else if (smp_valid) flags <= f_nxt;
  end

  // R6: kill level lies above the cut level, so kill implies cut
  a_r6_kill_in_cut: assert property (@(posedge clk) disable iff (!rst_n)
    flags.gate_kill |-> flags.duty_cut);
  // R8: peak level lies below the soft level, so peak implies soft
  a_r8_peak_in_soft: assert property (@(posedge clk) disable iff (!rst_n)
    flags.peak_lim |-> flags.soft_oc);
  // R9: flags hold without a strobe
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(flags));
endmodule

// File: rtl/pfc_mode_fsm.sv
module pfc_mode_fsm
  import pfc_sup_pkg::*;
#(
  parameter int W        = 16,
  parameter int OLP_MV   = 600,
  parameter int RUN_MV   = 2850,
  parameter int BOOST_MV = 2490
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic                ok_nxt,
  input  logic                ok_q,
  input  logic signed [W-1:0] fb_mv,
  output pfc_mode_e           mode
);
  localparam logic signed [W-1:0] OLP_T   = W'(OLP_MV);
  localparam logic signed [W-1:0] RUN_T   = W'(RUN_MV);
  localparam logic signed [W-1:0] BOOST_T = W'(BOOST_MV);

  pfc_mode_e m_nxt;

  always_comb begin
    m_nxt = mode;
    if (smp_valid) begin
      if (!ok_nxt)            m_nxt = M_OFF;
      else if (fb_mv < OLP_T) m_nxt = M_STANDBY;
      else begin
        unique case (mode)
          M_OFF, M_STANDBY: m_nxt = M_STARTUP;
          M_STARTUP:        m_nxt = (fb_mv >= RUN_T) ? M_NORMAL : M_STARTUP;
          M_NORMAL:         m_nxt = (fb_mv < BOOST_T) ? M_STARTUP : M_NORMAL;
          default:          m_nxt = M_OFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= M_OFF;
    else        mode <= m_nxt;
  end

  // R2: an unqualified supply always shows as OFF
  a_r2_off_when_unq: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_q |-> (mode == M_OFF));
  // R3: low feedback with a good supply lands in standby
  a_r3_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ok_nxt && (fb_mv < OLP_T)) |=> (mode == M_STANDBY));
  // R5: NORMAL is only reached through STARTUP
  a_r5_via_startup: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(mode) && (mode == M_NORMAL) |-> ($past(mode) == M_STARTUP));
  // R9: mode holds without a strobe
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(mode));
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic signed [W-1:0] vcc_mv,
  input  logic signed [W-1:0] fb_mv,
  input  logic signed [W-1:0] cs_mv,
  output logic [1:0]          mode,
  output logic                gate_en,
  output logic                comp_rst,
  output logic                duty_cut,
  output logic                gate_kill,
  output logic                win_hi,
  output logic                win_lo,
  output logic                soft_oc,
  output logic                peak_lim
);
  logic       ok_nxt, ok_q;
  pfc_mode_e  mode_q;
  pfc_flags_t flags;

  pfc_supply_hyst #(.W(W)) u_hyst (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .vcc_mv(vcc_mv),
    .ok_nxt(ok_nxt), .ok_q(ok_q)
  );

  pfc_mode_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .ok_nxt(ok_nxt),
    .ok_q(ok_q), .fb_mv(fb_mv), .mode(mode_q)
  );

  pfc_level_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .fb_mv(fb_mv),
    .cs_mv(cs_mv), .flags(flags)
  );

  assign mode      = mode_q;
  assign comp_rst  = (mode_q == M_OFF) || (mode_q == M_STANDBY);
  assign gate_en   = !comp_rst && !flags.gate_kill;
  assign duty_cut  = flags.duty_cut;
  assign gate_kill = flags.gate_kill;
  assign win_hi    = flags.win_hi;
  assign win_lo    = flags.win_lo;
  assign soft_oc   = flags.soft_oc;
  assign peak_lim  = flags.peak_lim;

  // R11: the gate only turns on after a strobed sample
  a_r11_gate_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(smp_valid));
  // R7: the two window flags never overlap
  a_r7_window_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_hi && win_lo));
endmodule

// File: tb/tb_pfc_supervisor.sv
module tb_pfc_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [15:0] vcc_mv = '0, fb_mv = '0, cs_mv = '0;
  logic [1:0] mode;
  logic gate_en, comp_rst, duty_cut, gate_kill, win_hi, win_lo, soft_oc, peak_lim;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit e_ok = 0;
  int e_mode = 0;
  bit e_cut, e_kill, e_hi, e_lo, e_soc, e_pk;

  always #10 clk = ~clk;

  pfc_supervisor dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .vcc_mv(vcc_mv),
    .fb_mv(fb_mv), .cs_mv(cs_mv), .mode(mode), .gate_en(gate_en),
    .comp_rst(comp_rst), .duty_cut(duty_cut), .gate_kill(gate_kill),
    .win_hi(win_hi), .win_lo(win_lo), .soft_oc(soft_oc), .peak_lim(peak_lim)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R10 mode", int'(mode), e_mode);
    chk("R4 comp_rst", int'(comp_rst), int'(e_mode < 2));
    chk("R11 gate_en", int'(gate_en), int'(e_mode >= 2 && !e_kill));
    chk("R6 duty_cut", int'(duty_cut), int'(e_cut));
    chk("R6 gate_kill", int'(gate_kill), int'(e_kill));
    chk("R7 win_hi", int'(win_hi), int'(e_hi));
    chk("R7 win_lo", int'(win_lo), int'(e_lo));
    chk("R8 soft_oc", int'(soft_oc), int'(e_soc));
    chk("R8 peak_lim", int'(peak_lim), int'(e_pk));
  endtask

  // expected state from the requirements for one accepted sample
  task automatic model(int v, int f, int c);
    if (e_ok && v < 11000) e_ok = 0;
    else if (!e_ok && v > 11800) e_ok = 1;
    if (!e_ok) e_mode = 0;
    else if (f < 600) e_mode = 1;
    else if (e_mode <= 1) e_mode = 2;
    else if (e_mode == 2) e_mode = (f >= 2850) ? 3 : 2;
    else e_mode = (f < 2490) ? 2 : 3;
    e_cut = f > 3150; e_kill = f > 3250;
    e_hi = f > 3180;  e_lo = f < 2850;
    e_soc = c < -750; e_pk = c <= -1040;
  endtask

  task automatic smp(int v, int f, int c);
    @(negedge clk);
    vcc_mv = 16'(v); fb_mv = 16'(f); cs_mv = 16'(c); smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    model(v, f, c);
    chk_all();
  endtask

  // R9: inputs without strobe must not move anything
  task automatic idle_noise(int v, int f, int c);
    @(negedge clk);
    vcc_mv = 16'(v); fb_mv = 16'(f); cs_mv = 16'(c);
    @(negedge clk);
    @(negedge clk);
    chk("R9 mode hold", int'(mode), e_mode);
    chk("R9 kill hold", int'(gate_kill), int'(e_kill));
    chk("R9 peak hold", int'(peak_lim), int'(e_pk));
    chk("R9 lo hold", int'(win_lo), int'(e_lo));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset mode", int'(mode), 0);
    chk("R10 reset flags", int'({duty_cut, gate_kill, win_hi, win_lo, soft_oc, peak_lim}), 0);
    chk("R10 reset gate", int'(gate_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: exact boundary does not qualify
    smp(11800, 3000, 0);
    chk("R1 at 11800 stays OFF", int'(mode), 0);
    smp(11801, 3000, 0);
    chk("R1 above 11800 leaves OFF", int'(mode), 2);
    // R2: band holds, then drop
    smp(11000, 3000, 0);
    chk("R2 at 11000 holds", int'(mode), 3);
    smp(10999, 3000, 0);
    chk("R2 below 11000 OFF", int'(mode), 0);
    // supply sweep both ways
    for (int v = 10000; v <= 13000; v += 50) smp(v, 1500, 0);
    for (int v = 13000; v >= 10000; v -= 50) smp(v, 1500, 0);
    smp(12500, 1500, 0);
    // R3 / R5 feedback sweep up and down with supply qualified
    for (int f = -100; f <= 3500; f += 10) smp(12500, f, 0);
    for (int f = 3500; f >= -100; f -= 10) smp(12500, f, 0);
    chk("R3 standby at low fb", int'(mode), 1);
    // R5 explicit boundaries
    smp(12500, 700, 0);
    chk("R4 standby to startup", int'(mode), 2);
    smp(12500, 2849, 0);
    chk("R5 2849 stays startup", int'(mode), 2);
    smp(12500, 2850, 0);
    chk("R5 2850 to normal", int'(mode), 3);
    smp(12500, 2490, 0);
    chk("R5 2490 stays normal", int'(mode), 3);
    smp(12500, 2489, 0);
    chk("R5 2489 back to startup", int'(mode), 2);
    // R6 edges
    smp(12500, 3150, 0); chk("R6 3150 no cut", int'(duty_cut), 0);
    smp(12500, 3251, 0); chk("R11 kill drops gate", int'(gate_en), 0);
    // R8 current sweep
    for (int c = -1200; c <= 100; c += 5) smp(12500, 3000, c);
    smp(12500, 3000, -750);  chk("R8 -750 no soft", int'(soft_oc), 0);
    smp(12500, 3000, -1040); chk("R8 -1040 peak", int'(peak_lim), 1);
    // R9 unstrobed changes
    idle_noise(9000, 200, -2000);
    idle_noise(12500, 3400, 500);
    smp(12500, 3000, 0);
    idle_noise(9000, 3400, -1100);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule